// File: doc/BRIEF.md
# Sliced Link Stage with Per-Lane Flow Control

This block carries a wide flit stream across a link that has been cut into narrow, independently controlled lanes. With the default parameters, a 32-bit word is split into sixteen 2-bit digits, and each digit travels in its own lane. Each lane has a sender-side buffer, its own valid/ready handshake across the link and a receiver-side buffer. Because the lanes do not move in lock-step, at any cycle some lanes may already hold a later word while others are still carrying an earlier one.

The front end takes an upstream word only when every lane can store its digit in that cycle. The back end rebuilds and presents a word only once every lane has its digit for that word at the head of its receive buffer, and then releases all lanes together. Each digit carries a copy of the word's end-of-frame flag, so head, body and tail flits are sliced in the same way.

A per-lane hold input blocks the link handshake of the lanes it selects. It stands in for wire skew or a slow lane, and makes it possible to drive the lanes out of step on purpose.

Top module: `slink_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `down_valid` is 0 and `up_ready` is 1.
- R2: Lane i carries bits [2i+1:2i] of each word. Words appear at `down_data` unchanged and in the order they were accepted (`up_valid && up_ready` at a rising edge).
- R3: The end-of-frame flag given with a word at the upstream side appears on `down_eof` with that same word. All lanes agree on the flag of the word being presented.
- R4: `up_ready` is 1 only when the sender buffer of every lane has room. While one lane is held and the sink is ready, the link accepts exactly DEPTH (2) words and then drops `up_ready`.
- R5: `down_valid` is 1 only when every lane has a digit at the head of its receive buffer. While any lane that holds the oldest undelivered digit is held, `down_valid` stays 0.
- R6: `lane_hold` is sampled at the rising edge. When a held lane is released and every other lane already holds the next word, `down_valid` rises right after the first rising edge at which the hold is low.
- R7: While `down_valid` is 1 and `down_ready` is 0, the next cycle still shows `down_valid` at 1 with the same `down_data` and `down_eof`.
- R8: Reset discards every word in flight. After reset no stale word is delivered, and new words pass normally.
- R9: With `down_ready` held at 0 and no lane held, the link accepts exactly 2*DEPTH (4) words before `up_ready` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream word is valid |
| up_data | input | 32 | Upstream word |
| up_eof | input | 1 | Upstream word is the tail flit |
| up_ready | output | 1 | All lanes can take a digit |
| lane_hold | input | 16 | Per-lane link stall, bit i blocks lane i |
| down_valid | output | 1 | Rebuilt word is available |
| down_data | output | 32 | Rebuilt word |
| down_eof | output | 1 | Rebuilt word is the tail flit |
| down_ready | input | 1 | Sink takes the word this cycle |

## Verification
The hardest condition to reach is lane skew: some lanes have already moved a word into their receive buffers while one lane still holds it on the sender side, so the merge must wait and then resume as soon as the lagging digit crosses. The stimulus holds one lane until its sender buffer fills and `up_ready` falls, confirms that no word is presented, releases the lane and checks the exact cycle at which `down_valid` rises. A second stream changes the per-lane holds and the sink readiness at random every cycle, so the lanes drift apart and come back together repeatedly while the scoreboard checks order, data and end-of-frame.

// File: rtl/slink_pkg.sv
package slink_pkg;
   // Default geometry of the sliced link
   parameter int unsigned SLK_WORD_W  = 32;
   parameter int unsigned SLK_SLICE_W = 2;
   parameter int unsigned SLK_DEPTH   = 2;
endpackage

// File: rtl/slink_fifo.sv
module slink_fifo #(
   parameter int unsigned W     = 3,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         in_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         out_ready
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic          push, pop;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign in_ready  = (cnt_q != CW'(DEPTH));
   assign out_valid = (cnt_q != '0);
   assign out_data  = mem[rd_q];
   assign push      = in_valid && in_ready;
   assign pop       = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= bump(wr_q);
         if (pop)  rd_q <= bump(rd_q);
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= in_data;
   end
endmodule

// File: rtl/slink_lane.sv
module slink_lane #(
   parameter int unsigned SLICE_W = 2,
   parameter int unsigned DEPTH   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic               in_valid,
   input  logic [SLICE_W-1:0] in_dig,
   input  logic               in_eof,
   output logic               in_ready,
   output logic               out_valid,
   output logic [SLICE_W-1:0] out_dig,
   output logic               out_eof,
   input  logic               out_ready
);
   localparam int unsigned EW = SLICE_W + 1;

   logic          tx_valid, tx_ready, rx_ready;
   logic [EW-1:0] tx_data, rx_data;

   // sender-side buffer
   slink_fifo #(.W(EW), .DEPTH(DEPTH)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data({in_eof, in_dig}), .in_ready(in_ready),
      .out_valid(tx_valid), .out_data(tx_data), .out_ready(tx_ready)
   );

   // per-lane link handshake, blocked while held
   assign tx_ready = rx_ready && !hold;

   // receiver-side buffer
   slink_fifo #(.W(EW), .DEPTH(DEPTH)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .in_valid(tx_valid && !hold), .in_data(tx_data), .in_ready(rx_ready),
      .out_valid(out_valid), .out_data(rx_data), .out_ready(out_ready)
   );

   assign out_dig = rx_data[SLICE_W-1:0];
   assign out_eof = rx_data[SLICE_W];
endmodule

// File: rtl/slink_top.sv
module slink_top
   import slink_pkg::*;
#(
   parameter int unsigned WORD_W  = SLK_WORD_W,
   parameter int unsigned SLICE_W = SLK_SLICE_W,
   parameter int unsigned DEPTH   = SLK_DEPTH,
   localparam int unsigned NL     = WORD_W / SLICE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   input  logic [WORD_W-1:0] up_data,
   input  logic              up_eof,
   output logic              up_ready,
   input  logic [NL-1:0]     lane_hold,
   output logic              down_valid,
   output logic [WORD_W-1:0] down_data,
   output logic              down_eof,
   input  logic              down_ready
);
   if (SLICE_W == 0 || (WORD_W % SLICE_W) != 0) begin : g_bad_slice
      $error("WORD_W must be a nonzero multiple of SLICE_W");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end

   logic [NL-1:0] lane_in_ready, lane_out_valid, lane_out_eof;
   logic          push_all, pop_all;

   // slicing front end: admit a word only if all lanes have room
   assign up_ready = &lane_in_ready;
   assign push_all = up_valid && up_ready;

   // merge back end: present only when every lane head is present
   assign down_valid = &lane_out_valid;
   assign pop_all    = down_valid && down_ready;
   assign down_eof   = lane_out_eof[0];

   for (genvar i = 0; i < NL; i++) begin : g_lane
      slink_lane #(.SLICE_W(SLICE_W), .DEPTH(DEPTH)) u_lane (
         .clk(clk), .rst_n(rst_n), .hold(lane_hold[i]),
         .in_valid(push_all),
         .in_dig(up_data[i*SLICE_W +: SLICE_W]),
         .in_eof(up_eof),
         .in_ready(lane_in_ready[i]),
         .out_valid(lane_out_valid[i]),
         .out_dig(down_data[i*SLICE_W +: SLICE_W]),
         .out_eof(lane_out_eof[i]),
         .out_ready(pop_all)
      );
   end
endmodule

// File: rtl/slink_chk.sv
module slink_chk #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned SLICE_W = 2,
   parameter int unsigned DEPTH   = 2,
   localparam int unsigned NL     = WORD_W / SLICE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_valid,
   input logic              up_ready,
   input logic [NL-1:0]     lane_hold,
   input logic              down_valid,
   input logic [WORD_W-1:0] down_data,
   input logic              down_eof,
   input logic              down_ready,
   input logic [NL-1:0]     lane_eofs
);
   localparam int unsigned CAP = 2 * DEPTH;
   localparam int unsigned CW  = $clog2(CAP + 2);

   logic [CW-1:0] inflight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= '0;
      else inflight <= inflight + CW'(up_valid && up_ready) - CW'(down_valid && down_ready);
   end

   AST_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CW'(CAP)); // R9
   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      inflight == CW'(CAP) |-> !up_ready); // R4
   AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      inflight == '0 |-> !down_valid); // R5
   AST_ALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((&lane_hold) && !down_valid) |=> !down_valid); // R5
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (down_valid && !down_ready) |=> (down_valid && $stable(down_data) && $stable(down_eof))); // R7
   AST_EOF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      down_valid |-> ((&lane_eofs) || !(|lane_eofs))); // R3
endmodule

bind slink_top slink_chk #(.WORD_W(WORD_W), .SLICE_W(SLICE_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
   .lane_hold(lane_hold), .down_valid(down_valid), .down_data(down_data),
   .down_eof(down_eof), .down_ready(down_ready), .lane_eofs(lane_out_eof)
);

// File: tb/sim_slink_top.sv
module sim_slink_top;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_valid = 1'b0;
   logic [31:0] up_data = '0;
   logic        up_eof = 1'b0;
   logic        up_ready;
   logic [15:0] lane_hold = '0;
   logic        down_valid;
   logic [31:0] down_data;
   logic        down_eof;
   logic        sink_rdy = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   logic [32:0] sb[$];

   always #2.5 clk = ~clk;

   slink_top u0 (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data),
      .up_eof(up_eof), .up_ready(up_ready), .lane_hold(lane_hold),
      .down_valid(down_valid), .down_data(down_data), .down_eof(down_eof),
      .down_ready(sink_rdy)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one attempt: drive at negedge, decide acceptance just before the rising edge
   task automatic push_try(input logic [31:0] d, input logic e, input bit jitter, output bit acc);
      @(negedge clk);
      up_valid = 1'b1;
      up_data  = d;
      up_eof   = e;
      if (jitter) begin
         lane_hold = 16'($urandom & $urandom & $urandom);
         sink_rdy  = 1'($urandom);
      end
      #2;
      acc = up_ready;
      if (acc) sb.push_back({e, d});
   endtask

   task automatic send(input logic [31:0] d, input logic e, input bit jitter);
      bit acc = 1'b0;
      while (!acc) push_try(d, e, jitter, acc);
   endtask

   task automatic idle();
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic drain();
      for (int k = 0; k < 200 && sb.size() != 0; k++) @(negedge clk);
      chk(sb.size() == 0, "R2 drain", 64'(sb.size()), 0);
   endtask

   // scoreboard monitor
   always begin
      @(negedge clk);
      #2;
      if (rst_n && down_valid && sink_rdy) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R2 unexpected word", 64'(down_data), 0);
         end else begin
            logic [32:0] ex;
            ex = sb.pop_front();
            chk(down_data == ex[31:0], "R2 data", 64'(down_data), 64'(ex[31:0]));
            chk(down_eof == ex[32], "R3 eof", 64'(down_eof), 64'(ex[32]));
         end
      end
   end

   initial begin
      repeat (2000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      bit acc;
      int cnt;
      logic [31:0] d0;
      logic        e0;

      // R1: reset state
      repeat (3) @(negedge clk);
      #2;
      chk(!down_valid && up_ready, "R1 in reset", {down_valid, up_ready}, 2'b01);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk(!down_valid && up_ready, "R1 after reset", {down_valid, up_ready}, 2'b01);

      // R2/R3: plain stream with frame tails
      for (int i = 0; i < 20; i++) send($urandom, (i % 5) == 4, 1'b0);
      idle();
      drain();

      // R2/R3: skewed lanes and random sink stalls
      for (int i = 0; i < 40; i++) send($urandom, (i % 4) == 3, 1'b1);
      idle();
      lane_hold = '0;
      sink_rdy  = 1'b1;
      drain();

      // R9: capacity with sink stalled
      sink_rdy = 1'b0;
      cnt = 0;
      for (int i = 0; i < 8; i++) begin
         push_try(32'hA5A5_0000 + 32'(i), i == 3, 1'b0, acc);
         if (acc) cnt++;
      end
      chk(cnt == 4, "R9 capacity", 64'(cnt), 4);
      idle();
      // R7: stalled output stays put
      #2;
      d0 = down_data;
      e0 = down_eof;
      @(negedge clk);
      #2;
      chk(down_valid && down_data == d0 && down_eof == e0, "R7 stall stable",
          {down_valid, down_data}, {1'b1, d0});
      @(negedge clk);
      sink_rdy = 1'b1;
      drain();

      // R4/R5: one lane held blocks the link
      @(negedge clk);
      lane_hold = 16'h0020;
      cnt = 0;
      for (int i = 0; i < 8; i++) begin
         push_try(32'h1234_5600 + 32'(i), i == 1, 1'b0, acc);
         if (acc) cnt++;
      end
      chk(cnt == 2, "R4 held lane admits DEPTH words", 64'(cnt), 2);
      chk(!up_ready, "R4 up_ready low", 64'(up_ready), 0);
      chk(!down_valid, "R5 merge waits for held lane", 64'(down_valid), 0);
      // R6: release timing
      @(negedge clk);
      up_valid  = 1'b0;
      lane_hold = '0;
      #2;
      chk(!down_valid, "R6 before release edge", 64'(down_valid), 0);
      @(negedge clk);
      #1;
      chk(down_valid, "R6 one edge after release", 64'(down_valid), 1);
      drain();

      // R8: reset mid-stream discards words
      sink_rdy = 1'b0;
      for (int i = 0; i < 3; i++) send(32'hDEAD_0000 + 32'(i), 1'b0, 1'b0);
      idle();
      rst_n = 1'b0;
      sb.delete();
      @(negedge clk);
      rst_n = 1'b1;
      sink_rdy = 1'b1;
      #2;
      chk(!down_valid && up_ready, "R8 emptied by reset", {down_valid, up_ready}, 2'b01);
      repeat (3) @(negedge clk);
      #2;
      chk(!down_valid, "R8 no stale word", 64'(down_valid), 0);
      send(32'hC0DE_0001, 1'b0, 1'b0);
      send(32'hC0DE_0002, 1'b1, 1'b0);
      idle();
      drain();

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule